// File: doc/BRIEF.md
# Dual-Issue Pairing Dispatcher

This block sits between a fetch buffer and two issue buses, one for the F pipe and one for the M pipe. Every cycle it looks at the two oldest decoded instructions, slot 0 (older) and slot 1 (younger). It decides whether both can go together or whether the younger one has to wait a cycle. Each instruction carries a valid flag, a 2-bit class code, a 2-bit mask of the pipes it may use, and a data word. The block places each instruction it issues on the bus of the pipe it was given.

The pairing decision is combinational. The consume count goes back to the fetch buffer in the same cycle, so the buffer can drop the instructions that were taken. The chosen instructions are registered onto the two buses, which makes the issue step one pipeline stage after decode. A downstream stall freezes both buses and stops the buffer from advancing. Each pipe takes at most one instruction per cycle, and program order is never broken.

Top module: `dual_issue_pairer`

## Requirements
- R1: No pipe receives two instructions in one cycle. When both valid instructions can only use the same pipe (for example both masks F-only, or both M-only), the older one issues alone, the younger one slips, and consume is 1.
- R2: When a split is possible, both instructions issue and consume is 2. An instruction allowed on both pipes takes the pipe its partner cannot use. When both are allowed on both pipes, the older one goes to F and the younger one to M. If older-to-F and younger-to-M both fit, that split is preferred.
- R3: An instruction that issues without a partner goes on the F bus if its mask allows F, otherwise on the M bus. Mask bit 0 means F is allowed and mask bit 1 means M is allowed.
- R4: If slot 0 is valid with an empty mask, nothing issues that cycle and consume is 0, even when slot 1 could issue.
- R5: An invalid slot never drives a bus and never blocks the other slot. A valid slot 1 with slot 0 invalid issues alone with consume 1. When both slots are invalid, consume is 0 and both bus valids are low in the next cycle.
- R6: A bus carries the class code and data of the instruction placed on it, unchanged, one clock edge after the decision. Class codes are integer 0, load/store 1, floating-point 2, branch 3.
- R7: While stall is high, consume is 0, and the bus valids, classes and data keep the values they had before the edge.
- R8: A synchronous active-high reset clears both bus valids at the next edge.
- R9: When not stalled, the number of bus valids raised after an edge equals the consume count shown before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream stall; freezes both buses |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_class | input | 2 | Older slot class code |
| s0_pipes | input | 2 | Older slot pipe mask (bit0 F, bit1 M) |
| s0_data | input | DATA_W | Older slot data word |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_class | input | 2 | Younger slot class code |
| s1_pipes | input | 2 | Younger slot pipe mask (bit0 F, bit1 M) |
| s1_data | input | DATA_W | Younger slot data word |
| fbus_valid | output | 1 | F bus carries an instruction |
| fbus_class | output | 2 | F bus class code |
| fbus_data | output | DATA_W | F bus data word |
| mbus_valid | output | 1 | M bus carries an instruction |
| mbus_class | output | 2 | M bus class code |
| mbus_data | output | DATA_W | M bus data word |
| consume | output | 2 | Instructions taken from the buffer this cycle |

## Verification
Some rules are checked by assertions on every cycle. These are: the two buses never take the same slot, a stall freezes each bus and zeroes consume, an older instruction with no allowed pipe blocks everything, an empty pair consumes nothing, and the bus valid count follows the previous consume count. Other behaviour needs the bench's scenarios. That includes which pipe a dual-eligible instruction lands on, the older-first preference, the exact class and data on each bus, and the slip where the younger instruction becomes the older one in the next cycle.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [1:0] {
    CLS_INT    = 2'd0,
    CLS_LDST   = 2'd1,
    CLS_FP     = 2'd2,
    CLS_BRANCH = 2'd3
  } instr_class_e;

  localparam int PIPE_F = 0;
  localparam int PIPE_M = 1;

  typedef struct packed {
    logic       f_use;
    logic       f_src;
    logic       m_use;
    logic       m_src;
    logic [1:0] count;
  } route_t;

  function automatic route_t route_single(input logic src, input logic [1:0] mask);
    route_t r;
    r = '0;
    if (mask[PIPE_F]) begin
      r.f_use = 1'b1;
      r.f_src = src;
    end else begin
      r.m_use = 1'b1;
      r.m_src = src;
    end
    r.count = 2'd1;
    return r;
  endfunction

  function automatic route_t route_pair(input logic v0, input logic [1:0] e0,
                                        input logic v1, input logic [1:0] e1);
    route_t r;
    r = '0;
    if (!v0) begin
      if (v1 && e1 != 2'b00) r = route_single(1'b1, e1);
    end else if (e0 == 2'b00) begin
      r = '0;
    end else if (!v1 || e1 == 2'b00) begin
      r = route_single(1'b0, e0);
    end else if (e0[PIPE_F] && e1[PIPE_M]) begin
      r.f_use = 1'b1; r.f_src = 1'b0;
      r.m_use = 1'b1; r.m_src = 1'b1;
      r.count = 2'd2;
    end else if (e0[PIPE_M] && e1[PIPE_F]) begin
      r.m_use = 1'b1; r.m_src = 1'b0;
      r.f_use = 1'b1; r.f_src = 1'b1;
      r.count = 2'd2;
    end else begin
      r = route_single(1'b0, e0);
    end
    return r;
  endfunction

endpackage

// File: rtl/pair_route_logic.sv
module pair_route_logic
  import pair_pkg::*;
(
  input  logic       v0,
  input  logic [1:0] e0,
  input  logic       v1,
  input  logic [1:0] e1,
  output logic       f_use,
  output logic       f_src,
  output logic       m_use,
  output logic       m_src,
  output logic [1:0] count
);
  route_t r;

  always_comb begin
    r     = route_pair(v0, e0, v1, e1);
    f_use = r.f_use;
    f_src = r.f_src;
    m_use = r.m_use;
    m_src = r.m_src;
    count = r.count;
  end

  // R1
  always_comb begin
    if (f_use && m_use) begin
      dual_src_chk: assert (f_src != m_src)
        else $error("both pipes routed from one slot");
    end
  end
endmodule

// File: rtl/bus_lane.sv
module bus_lane #(
  parameter int DATA_W = 32,
  localparam int PAY_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              take,
  input  logic              src,
  input  logic [PAY_W-1:0]  pay0,
  input  logic [PAY_W-1:0]  pay1,
  output logic              valid,
  output logic [PAY_W-1:0]  pay
);
  logic [PAY_W-1:0] pick;
  assign pick = src ? pay1 : pay0;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      pay   <= '0;
    end else if (!hold) begin
      valid <= take;
      pay   <= take ? pick : '0;
    end
  end

  // R7
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(valid) && $stable(pay)));
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import pair_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              s0_valid,
  input  logic [1:0]        s0_class,
  input  logic [1:0]        s0_pipes,
  input  logic [DATA_W-1:0] s0_data,
  input  logic              s1_valid,
  input  logic [1:0]        s1_class,
  input  logic [1:0]        s1_pipes,
  input  logic [DATA_W-1:0] s1_data,
  output logic              fbus_valid,
  output logic [1:0]        fbus_class,
  output logic [DATA_W-1:0] fbus_data,
  output logic              mbus_valid,
  output logic [1:0]        mbus_class,
  output logic [DATA_W-1:0] mbus_data,
  output logic [1:0]        consume
);
  localparam int PAY_W = DATA_W + 2;
  localparam int NLANE = 2;

  logic       f_use, f_src, m_use, m_src;
  logic [1:0] route_count;
  logic [PAY_W-1:0] pay0, pay1;
  logic [NLANE-1:0] lane_take, lane_src, lane_valid;
  logic [PAY_W-1:0] lane_pay [NLANE];

  assign pay0 = {s0_class, s0_data};
  assign pay1 = {s1_class, s1_data};

  pair_route_logic u_route (
    .v0(s0_valid), .e0(s0_pipes), .v1(s1_valid), .e1(s1_pipes),
    .f_use(f_use), .f_src(f_src), .m_use(m_use), .m_src(m_src),
    .count(route_count)
  );

  assign lane_take = {m_use, f_use};
  assign lane_src  = {m_src, f_src};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    bus_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst(rst), .hold(stall),
      .take(lane_take[g]), .src(lane_src[g]),
      .pay0(pay0), .pay1(pay1),
      .valid(lane_valid[g]), .pay(lane_pay[g])
    );
  end

  assign consume    = stall ? 2'd0 : route_count;
  assign fbus_valid = lane_valid[PIPE_F];
  assign mbus_valid = lane_valid[PIPE_M];
  assign {fbus_class, fbus_data} = lane_pay[PIPE_F];
  assign {mbus_class, mbus_data} = lane_pay[PIPE_M];

  // R9
  consume_match_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (2'(fbus_valid) + 2'(mbus_valid)) == $past(consume));

  // R7
  stall_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> consume == 2'd0);

  // R4
  older_block_chk: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && s0_pipes == 2'b00) |-> consume == 2'd0);

  // R5
  empty_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!s0_valid && !s1_valid && !stall) |=> (!fbus_valid && !mbus_valid));
endmodule

// File: tb/dual_issue_pairer_bench.sv
module dual_issue_pairer_bench;
  localparam int DATA_W = 32;
  localparam int NVEC = 16;
  // {v0, e0[1:0], v1, e1[1:0], exp_fv, exp_fsrc, exp_mv, exp_msrc, exp_cons[1:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b1_01_1_10_1_0_1_1_10,  // R2 F + M
    12'b1_10_1_01_1_1_1_0_10,  // R2 M + F
    12'b1_01_1_01_1_0_0_0_01,  // R1 F + F slip
    12'b1_10_1_10_0_0_1_0_01,  // R1 M + M slip
    12'b1_11_1_01_1_1_1_0_10,  // R2 both + F
    12'b1_11_1_10_1_0_1_1_10,  // R2 both + M
    12'b1_11_1_11_1_0_1_1_10,  // R2 both + both
    12'b1_01_1_11_1_0_1_1_10,  // R2 F + both
    12'b1_10_1_11_1_1_1_0_10,  // R2 M + both
    12'b1_00_1_01_0_0_0_0_00,  // R4 older no pipe
    12'b0_01_1_10_0_0_1_1_01,  // R5 older invalid
    12'b1_01_0_10_1_0_0_0_01,  // R5 younger invalid
    12'b0_11_0_11_0_0_0_0_00,  // R5 both invalid
    12'b1_11_0_01_1_0_0_0_01,  // R3 single both
    12'b0_10_1_11_1_1_0_0_01,  // R3 single younger
    12'b1_01_1_00_1_0_0_0_01   // R3 younger no pipe
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic s0_valid = 1'b0, s1_valid = 1'b0;
  logic [1:0] s0_class = '0, s1_class = '0, s0_pipes = '0, s1_pipes = '0;
  logic [DATA_W-1:0] s0_data = '0, s1_data = '0;
  logic fbus_valid, mbus_valid;
  logic [1:0] fbus_class, mbus_class, consume;
  logic [DATA_W-1:0] fbus_data, mbus_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_issue_pairer #(.DATA_W(DATA_W)) u_dual_issue_pairer (
    .clk(clk), .rst(rst), .stall(stall),
    .s0_valid(s0_valid), .s0_class(s0_class), .s0_pipes(s0_pipes), .s0_data(s0_data),
    .s1_valid(s1_valid), .s1_class(s1_class), .s1_pipes(s1_pipes), .s1_data(s1_data),
    .fbus_valid(fbus_valid), .fbus_class(fbus_class), .fbus_data(fbus_data),
    .mbus_valid(mbus_valid), .mbus_class(mbus_class), .mbus_data(mbus_data),
    .consume(consume)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v0, input logic [1:0] c0, input logic [1:0] e0,
                       input logic [DATA_W-1:0] d0,
                       input logic v1, input logic [1:0] c1, input logic [1:0] e1,
                       input logic [DATA_W-1:0] d1);
    s0_valid = v0; s0_class = c0; s0_pipes = e0; s0_data = d0;
    s1_valid = v1; s1_class = c1; s1_pipes = e1; s1_data = d1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] hold_f, hold_m;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 f valid after reset", fbus_valid, 0);
    chk("R8 m valid after reset", mbus_valid, 0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      logic [DATA_W-1:0] d0, d1, ef, em;
      logic [1:0] c0, c1, cf, cm;
      v  = VEC[i];
      d0 = {16'hA0A0, 16'(i)};
      d1 = {16'hB0B0, 16'(i)};
      c0 = 2'(i);
      c1 = ~2'(i);
      drive(v[11], c0, v[10:9], d0, v[8], c1, v[7:6], d1);
      #1;
      chk("R1/R2/R3 consume", consume, v[1:0]);
      ef = v[4] ? d1 : d0;  cf = v[4] ? c1 : c0;
      em = v[2] ? d1 : d0;  cm = v[2] ? c1 : c0;
      @(negedge clk);
      chk("R9 f valid", fbus_valid, v[5]);
      chk("R9 m valid", mbus_valid, v[3]);
      if (v[5]) begin
        chk("R6 f data", fbus_data, ef);
        chk("R6 f class", fbus_class, cf);
      end
      if (v[3]) begin
        chk("R6 m data", mbus_data, em);
        chk("R6 m class", mbus_class, cm);
      end
    end

    // R7 stall holds outputs and zeroes consume
    drive(1, 2'd0, 2'b01, 32'h1111_0000, 1, 2'd2, 2'b10, 32'h2222_0000);
    @(negedge clk);
    hold_f = fbus_data; hold_m = mbus_data;
    stall = 1'b1;
    drive(1, 2'd1, 2'b10, 32'h3333_0000, 1, 2'd3, 2'b01, 32'h4444_0000);
    #1;
    chk("R7 consume under stall", consume, 0);
    @(negedge clk);
    chk("R7 f data held", fbus_data, hold_f);
    chk("R7 m data held", mbus_data, hold_m);
    chk("R7 f class held", fbus_class, 2'd0);
    chk("R7 f valid held", fbus_valid, 1);
    stall = 1'b0;

    // R1 slip: younger becomes older next cycle
    drive(1, 2'd2, 2'b01, 32'h5555_0001, 1, 2'd2, 2'b01, 32'h5555_0002);
    #1;
    chk("R1 slip consume", consume, 1);
    @(negedge clk);
    chk("R1 older on F", fbus_data, 32'h5555_0001);
    drive(1, 2'd2, 2'b01, 32'h5555_0002, 0, 2'd0, 2'b00, 32'h0);
    #1;
    chk("R1 shifted consume", consume, 1);
    @(negedge clk);
    chk("R1 younger on F next", fbus_data, 32'h5555_0002);
    chk("R1 M idle", mbus_valid, 0);

    // R4 older blocked while younger could go
    drive(1, 2'd1, 2'b00, 32'h6, 1, 2'd1, 2'b11, 32'h7);
    #1;
    chk("R4 blocked consume", consume, 0);
    @(negedge clk);
    chk("R4 f idle", fbus_valid, 0);
    chk("R4 m idle", mbus_valid, 0);

    // R8 reset mid-run
    drive(1, 2'd0, 2'b01, 32'h8, 1, 2'd0, 2'b10, 32'h9);
    @(negedge clk);
    chk("R8 f busy before reset", fbus_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 f cleared", fbus_valid, 0);
    chk("R8 m cleared", mbus_valid, 0);
    rst = 1'b0;
    drive(0, 2'd0, 2'b00, 32'h0, 0, 2'd0, 2'b00, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule